// File: doc/BRIEF.md
# I2C Master Byte Controller

This block lets a host processor run transfers on a two-wire I2C bus one byte at a time. The host talks to it through a small register window: an 8-bit data bus, a 3-bit address, and a strobe/cycle pair that the block acknowledges. The host sets a 16-bit clock divider, turns the core on, places a byte in the transmit register and writes a command word. The command word can ask for a start condition, a byte written or read, and a stop condition. The block then runs the bus on its own and reports through a status register while it is busy and which acknowledge the slave returned.

Both bus lines are open-drain. For each line the block has a constant-low output, an output-enable that pulls the line low, and an input that sees the actual line level. A slave that holds SCL low pauses the master's bit timing until the line is seen high again. Combined commands always run in the same order: start, then the data byte and its acknowledge bit, then stop. A start issued while the bus is still owned gives a repeated start, so a read address can follow a write phase without a stop in between.

Top module: `i2c_host_ctrl`

## Requirements
- R1: Register window: address 0 is the divider low byte, 1 the divider high byte, 2 the control register. Address 3 writes the transmit byte and reads the receive byte. Address 4 writes the command word and reads status. Addresses 0 to 2 read back the value last written. The divider resets to 0xFFFF.
- R2: An access with strobe and cycle both high gets bus_ack exactly one cycle later, for one cycle only. Read data is valid in the cycle ack is high.
- R3: Control bit 7 enables the core. While it is 0, command writes are ignored, both output-enables stay 0 and status bit 1 stays 0.
- R4: Command bits are: 7 start, 6 stop, 5 read byte, 4 write byte, 3 acknowledge level the master sends after a read (1 = NACK). Combined bits run in the order start, byte plus acknowledge bit, stop. For example, 0x50 sends the byte and then the stop.
- R5: A start command while the bus is owned (after a byte and with no stop) produces a repeated start with no stop condition before it.
- R6: Status bit 1 is 1 from the cycle a command is accepted until its last bus action ends. Command writes made while it is 1 are ignored.
- R7: A write byte is shifted out MSB first. SDA is then released for the ninth clock, and the level sampled there is stored in status bit 7 (1 = NACK).
- R8: A read byte is sampled MSB first into the receive register. On the ninth clock the master drives the level given by command bit 3.
- R9: An output-enable of 1 pulls its line low, and 0 releases it to send a 1. Within data and acknowledge bits, SDA changes only while SCL is low.
- R10: Each data or acknowledge bit holds SCL released for exactly 2 × (divider + 1) clock cycles when no slave stretches the clock. A bit takes 5 × (divider + 1) cycles.
- R11: While a slave holds SCL low, the master's bit timing and both output-enables stay frozen. The transfer finishes correctly after SCL is released.
- R12: A stop-only command (0x40) produces a stop condition and no data clocks, and it leaves both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data from host |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_stb | input | 1 | Access strobe |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_ack | output | 1 | Access acknowledge, one cycle after request |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| scl_i | input | 1 | SCL line level |
| scl_o | output | 1 | SCL output level (always 0) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA output level (always 0) |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong phase or divider count shows up on the pads within one bit time (5 × (divider + 1) cycles). It appears as a wrong SCL high width, or as SDA moving while SCL is high, which a listening slave reads as a spurious start or stop. A wrong byte-sequencer state shows up at the end of the command. The slave then sees a wrong byte, a missing or extra start or stop, or a misplaced acknowledge. The host also sees status bit 1 clear too early, or never clear. A stretch that is not honoured makes SCL rise while the slave still holds it, so the released-line check and the transfer duration disagree within the stretch window.

// File: rtl/i2c_host_pkg.sv
// Package: shared constants and types for the I2C host controller.
// Assumes an 8-bit register window with a 3-bit address.
package i2c_host_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int PRE_W    = 2 * DATA_W;
    localparam int PHASES   = 5;
    localparam int PHASE_W  = $clog2(PHASES);
    localparam int SAMPLE_PH = PHASES - 2;

    localparam logic [ADDR_W-1:0] A_PRE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMD    = 3'd4;

    localparam int CTL_EN   = 7;
    localparam int ST_RXACK = 7;
    localparam int ST_TIP   = 1;

    // command word bits, passed as bits [7:3]
    localparam int CW_STA  = 4;
    localparam int CW_STO  = 3;
    localparam int CW_RD   = 2;
    localparam int CW_WR   = 1;
    localparam int CW_NACK = 0;

    typedef enum logic [1:0] {BOP_START, BOP_STOP, BOP_WRITE, BOP_READ} bit_op_e;
endpackage

// File: rtl/i2c_host_regs.sv
// Register window: decodes host accesses, stores divider/control/transmit,
// returns read data with a one-cycle acknowledge and raises cmd_go for an
// accepted command. Assumes the host holds strobe until it sees ack.
module i2c_host_regs
    import i2c_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_stb,
    input  logic              bus_cyc,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tip,
    input  logic              rxack,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [PRE_W-1:0]  prescale,
    output logic              core_en,
    output logic [DATA_W-1:0] tx_byte,
    output logic              cmd_go,
    output logic [4:0]        cmd_word
);
    logic [DATA_W-1:0] ctrl_q;
    logic acc, wr_acc;

    assign acc      = bus_stb & bus_cyc & ~bus_ack;
    assign wr_acc   = acc & bus_we;
    assign core_en  = ctrl_q[CTL_EN];
    assign cmd_word = bus_wdata[7:3];
    assign cmd_go   = wr_acc && (bus_addr == A_CMD) && core_en && !tip
                      && (|bus_wdata[7:4]);

    // acknowledge one cycle after request, single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) bus_ack <= 1'b0;
        else        bus_ack <= acc;
    end

    // register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale <= '1;
            ctrl_q   <= '0;
            tx_byte  <= '0;
        end else if (wr_acc) begin
            case (bus_addr)
                A_PRE_LO: prescale[DATA_W-1:0]     <= bus_wdata;
                A_PRE_HI: prescale[PRE_W-1:DATA_W] <= bus_wdata;
                A_CTRL:   ctrl_q                   <= bus_wdata;
                A_DATA:   tx_byte                  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // read data mux, registered with the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (acc && !bus_we) begin
            case (bus_addr)
                A_PRE_LO: bus_rdata <= prescale[DATA_W-1:0];
                A_PRE_HI: bus_rdata <= prescale[PRE_W-1:DATA_W];
                A_CTRL:   bus_rdata <= ctrl_q;
                A_DATA:   bus_rdata <= rx_byte;
                A_CMD: begin
                    bus_rdata           <= '0;
                    bus_rdata[ST_RXACK] <= rxack;
                    bus_rdata[ST_TIP]   <= tip;
                end
                default:  bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_host_bitseq.sv
// Bit sequencer: runs one bus bit action (start, stop, write bit, read bit)
// as PHASES timed phases of (prescale+1) cycles each. The line levels are
// registered. Timing freezes while SCL is released but seen low.
module i2c_host_bitseq
    import i2c_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale,
    input  logic             go,
    input  bit_op_e          op,
    input  logic             din,
    output logic             done,
    output logic             dout,
    output logic             busy,
    output bit_op_e          op_q,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_lvl,
    output logic             sda_lvl
);
    localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(PHASES - 1);
    localparam logic [PHASE_W-1:0] SMP_PH  = PHASE_W'(SAMPLE_PH);

    logic [PHASE_W-1:0] phase;
    logic [PRE_W-1:0]   cnt;
    logic               din_q;
    logic               hold;
    logic               want_scl, want_sda, scl_hi_ph;

    assign hold      = scl_lvl & ~scl_i;
    assign scl_hi_ph = (phase == 2) || (phase == SMP_PH);

    // line levels wanted in the current phase
    always_comb begin
        want_scl = 1'b1;
        want_sda = 1'b1;
        case (op_q)
            BOP_START: begin
                want_scl = (phase != 0) && (phase != LAST_PH);
                want_sda = (phase < 2);
            end
            BOP_STOP: begin
                want_scl = (phase != 0);
                want_sda = (phase >= SMP_PH);
            end
            BOP_WRITE: begin
                want_scl = scl_hi_ph;
                want_sda = din_q;
            end
            default: begin
                want_scl = scl_hi_ph;
                want_sda = 1'b1;
            end
        endcase
    end

    // phase timer, line registers and read sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            dout    <= 1'b0;
            phase   <= '0;
            cnt     <= '0;
            op_q    <= BOP_STOP;
            din_q   <= 1'b1;
            scl_lvl <= 1'b1;
            sda_lvl <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy  <= 1'b1;
                    phase <= '0;
                    cnt   <= prescale;
                    op_q  <= op;
                    din_q <= din;
                end
            end else begin
                scl_lvl <= want_scl;
                sda_lvl <= want_sda;
                if (!hold) begin
                    if (cnt == '0) begin
                        if (phase == SMP_PH) dout <= sda_i;
                        if (phase == LAST_PH) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            phase <= phase + 1'b1;
                            cnt   <= prescale;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_host_bytectl.sv
// Byte sequencer: turns one command word into start, eight data bits,
// the acknowledge bit and stop, in that order. Keeps the in-progress flag,
// the received acknowledge and the received byte.
module i2c_host_bytectl
    import i2c_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [4:0]        cmd_word,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              bc_done,
    input  logic              bc_dout,
    output logic              bc_go,
    output bit_op_e           bc_op,
    output logic              bc_din,
    output logic              tip,
    output logic              rxack,
    output logic [DATA_W-1:0] rx_byte
);
    typedef enum logic [2:0] {B_IDLE, B_START, B_DATA, B_ACK, B_STOP} bstate_e;

    bstate_e           st;
    logic              sto_q, xfer_q, wr_q, nack_q;
    logic [DATA_W-1:0] sh;
    logic [2:0]        bcnt;
    bit_op_e           data_op;

    assign data_op = wr_q ? BOP_WRITE : BOP_READ;

    // command sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= B_IDLE;
            tip     <= 1'b0;
            rxack   <= 1'b0;
            rx_byte <= '0;
            sh      <= '0;
            bcnt    <= '0;
            sto_q   <= 1'b0;
            xfer_q  <= 1'b0;
            wr_q    <= 1'b0;
            nack_q  <= 1'b0;
            bc_go   <= 1'b0;
            bc_op   <= BOP_STOP;
            bc_din  <= 1'b1;
        end else begin
            bc_go <= 1'b0;
            case (st)
                B_IDLE: if (cmd_go) begin
                    tip    <= 1'b1;
                    sto_q  <= cmd_word[CW_STO];
                    xfer_q <= cmd_word[CW_RD] | cmd_word[CW_WR];
                    wr_q   <= cmd_word[CW_WR];
                    nack_q <= cmd_word[CW_NACK];
                    sh     <= tx_byte;
                    bcnt   <= 3'd7;
                    bc_go  <= 1'b1;
                    if (cmd_word[CW_STA]) begin
                        st    <= B_START;
                        bc_op <= BOP_START;
                    end else if (cmd_word[CW_RD] | cmd_word[CW_WR]) begin
                        st     <= B_DATA;
                        bc_op  <= cmd_word[CW_WR] ? BOP_WRITE : BOP_READ;
                        bc_din <= tx_byte[DATA_W-1];
                    end else begin
                        st    <= B_STOP;
                        bc_op <= BOP_STOP;
                    end
                end
                B_START: if (bc_done) begin
                    if (xfer_q) begin
                        st     <= B_DATA;
                        bc_go  <= 1'b1;
                        bc_op  <= data_op;
                        bc_din <= sh[DATA_W-1];
                    end else if (sto_q) begin
                        st    <= B_STOP;
                        bc_go <= 1'b1;
                        bc_op <= BOP_STOP;
                    end else begin
                        st  <= B_IDLE;
                        tip <= 1'b0;
                    end
                end
                B_DATA: if (bc_done) begin
                    sh    <= {sh[DATA_W-2:0], wr_q ? 1'b0 : bc_dout};
                    bc_go <= 1'b1;
                    if (bcnt == '0) begin
                        st     <= B_ACK;
                        bc_op  <= wr_q ? BOP_READ : BOP_WRITE;
                        bc_din <= nack_q;
                    end else begin
                        bcnt   <= bcnt - 1'b1;
                        bc_op  <= data_op;
                        bc_din <= sh[DATA_W-2];
                    end
                end
                B_ACK: if (bc_done) begin
                    if (wr_q) rxack   <= bc_dout;
                    else      rx_byte <= sh;
                    if (sto_q) begin
                        st    <= B_STOP;
                        bc_go <= 1'b1;
                        bc_op <= BOP_STOP;
                    end else begin
                        st  <= B_IDLE;
                        tip <= 1'b0;
                    end
                end
                B_STOP: if (bc_done) begin
                    st  <= B_IDLE;
                    tip <= 1'b0;
                end
                default: st <= B_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_host_ctrl.sv
// Top: I2C master byte controller. Connects the register window, byte
// sequencer and bit sequencer, and maps line levels onto open-drain pads.
// Assumes external pull-ups on SCL and SDA.
module i2c_host_ctrl
    import i2c_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_stb,
    input  logic              bus_cyc,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              scl_i,
    output logic              scl_o,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe
);
    logic [PRE_W-1:0]  prescale;
    logic              core_en, cmd_go, tip, rxack;
    logic [4:0]        cmd_word;
    logic [DATA_W-1:0] tx_byte, rx_byte;
    logic              bc_go, bc_din, bc_done, bc_dout;
    bit_op_e           bc_op, bit_op_q;
    logic              bit_busy, bit_data_op;
    logic              scl_lvl, sda_lvl;

    i2c_host_regs u_regs (
        .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_stb, .bus_cyc,
        .bus_ack, .bus_rdata, .tip, .rxack, .rx_byte, .prescale, .core_en,
        .tx_byte, .cmd_go, .cmd_word
    );

    i2c_host_bytectl u_byte (
        .clk, .rst_n, .cmd_go, .cmd_word, .tx_byte, .bc_done, .bc_dout,
        .bc_go, .bc_op, .bc_din, .tip, .rxack, .rx_byte
    );

    i2c_host_bitseq u_bit (
        .clk, .rst_n, .prescale, .go(bc_go), .op(bc_op), .din(bc_din),
        .done(bc_done), .dout(bc_dout), .busy(bit_busy), .op_q(bit_op_q),
        .scl_i, .sda_i, .scl_lvl, .sda_lvl
    );

    // open-drain pad mapping
    assign bit_data_op = bit_busy && (bit_op_q == BOP_WRITE || bit_op_q == BOP_READ);
    assign scl_o  = 1'b0;
    assign sda_o  = 1'b0;
    assign scl_oe = ~scl_lvl;
    assign sda_oe = ~sda_lvl;
endmodule

// File: rtl/i2c_host_chk.sv
// Checker: protocol properties of the I2C host controller, bound to the top.
module i2c_host_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_stb,
    input logic bus_cyc,
    input logic bus_ack,
    input logic scl_oe,
    input logic sda_oe,
    input logic scl_i,
    input logic core_en,
    input logic tip,
    input logic bit_busy,
    input logic bit_data_op
);
    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_cyc && !bus_ack) |=> bus_ack); // R2
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R2
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_en && !tip) |=> ($stable(scl_oe) && $stable(sda_oe))); // R3
    AST_TIP_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_busy |-> tip); // R6
    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_data_op && $past(bit_data_op) && !scl_oe && !$past(scl_oe))
        |-> $stable(sda_oe)); // R9
    AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_busy && $past(bit_busy) && !scl_oe && !scl_i && $past(!scl_oe && !scl_i))
        |=> ($stable(scl_oe) && $stable(sda_oe))); // R11
endmodule

bind i2c_host_ctrl i2c_host_chk u_chk (.*);

// File: tb/sim_i2c_host_ctrl.sv
module sim_i2c_host_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0, bus_stb = 1'b0, bus_cyc = 1'b0;
    logic       bus_ack;
    logic [7:0] bus_rdata;
    logic       scl_o, scl_oe, sda_o, sda_oe;
    logic       stretch = 1'b0, slv_drv = 1'b0;
    logic       scl_ln, sda_ln;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int start_cnt = 0, stop_cnt = 0, byte_total = 0, bytes_at_stop = 0;
    int bitn = 0, byten = 0, hi_run = 0, last_high = 0;
    logic [7:0] shreg = '0, last_byte = '0;
    logic rmode = 1'b0, rdone = 1'b0, mack = 1'b0, slave_ack_en = 1'b1;
    logic p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] slv_tx;

    assign scl_ln = !(scl_oe | stretch);
    assign sda_ln = !(sda_oe | slv_drv);

    i2c_host_ctrl u0 (
        .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_stb, .bus_cyc,
        .bus_ack, .bus_rdata, .scl_i(scl_ln), .scl_o, .scl_oe,
        .sda_i(sda_ln), .sda_o, .sda_oe
    );

    always #2 clk = ~clk;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (scl_ln) hi_run = hi_run + 1;
        else begin
            if (hi_run > 0) last_high = hi_run;
            hi_run = 0;
        end
    end

    // behavioural slave with a write/read byte stream
    always @(scl_ln or sda_ln) begin
        if (scl_ln && p_scl && !sda_ln && p_sda) begin
            start_cnt = start_cnt + 1;
            bitn = 0; byten = 0; rmode = 0; rdone = 0; slv_drv = 0;
        end else if (scl_ln && p_scl && sda_ln && !p_sda) begin
            stop_cnt = stop_cnt + 1;
            bytes_at_stop = byte_total;
            rmode = 0; slv_drv = 0;
        end else if (scl_ln && !p_scl) begin
            if (bitn < 8) shreg = {shreg[6:0], sda_ln};
            else mack = sda_ln;
            bitn = bitn + 1;
            if (bitn == 9) begin
                bitn = 0;
                if (byten == 0) rmode = shreg[0];
                else if (rmode && mack) rdone = 1;
                last_byte = shreg;
                byte_total = byte_total + 1;
                byten = byten + 1;
            end
        end else if (!scl_ln && p_scl) begin
            slv_tx = (byten == 1) ? 8'h3C : 8'hC3;
            if (bitn == 8 && (byten == 0 || !rmode)) slv_drv = slave_ack_en;
            else if (rmode && byten >= 1 && bitn < 8 && !rdone) slv_drv = !slv_tx[7-bitn];
            else slv_drv = 0;
        end
        p_scl = scl_ln;
        p_sda = sda_ln;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1; bus_stb = 1; bus_cyc = 1;
        @(negedge clk);
        if (!bus_ack) begin n_fail++; $display("FAIL R2 write ack actual=0 expected=1"); end
        bus_stb = 0; bus_cyc = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 0; bus_stb = 1; bus_cyc = 1;
        @(negedge clk);
        if (!bus_ack) begin n_fail++; $display("FAIL R2 read ack actual=0 expected=1"); end
        d = bus_rdata;
        bus_stb = 0; bus_cyc = 0;
    endtask

    task automatic wait_tip(output logic [7:0] st);
        st = 8'h02;
        for (int i = 0; i < 5000 && st[1]; i++) bus_rd(3'd4, st);
    endtask

    // register vectors: {addr, write data, expected read-back}
    localparam logic [18:0] VEC [6] = '{
        {3'd0, 8'hC8, 8'hC8}, {3'd1, 8'h00, 8'h00}, {3'd2, 8'h05, 8'h05},
        {3'd0, 8'h5A, 8'h5A}, {3'd1, 8'h12, 8'h12}, {3'd2, 8'h00, 8'h00}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r, st;
        int t0, t_plain, t_str, s0, p0;
        bit drove;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // reset state
        @(negedge clk);
        chk(!scl_oe && !sda_oe && !bus_ack, "R9 reset lines released", {scl_oe, sda_oe}, 0);
        bus_rd(3'd4, r); chk(r == 8'h00, "R6 reset status", r, 0);
        bus_rd(3'd0, r); chk(r == 8'hFF, "R1 reset divider low", r, 8'hFF);
        // R2 ack is a one-cycle pulse
        @(negedge clk); chk(!bus_ack, "R2 ack falls", bus_ack, 0);
        // register vector walk (R1)
        foreach (VEC[i]) begin
            bus_wr(VEC[i][18:16], VEC[i][15:8]);
            bus_rd(VEC[i][18:16], r);
            chk(r == VEC[i][7:0], "R1 read-back", r, VEC[i][7:0]);
        end
        bus_wr(3'd0, 8'h03); bus_wr(3'd1, 8'h00);
        // disabled core ignores commands (R3)
        bus_wr(3'd3, 8'hA5); bus_wr(3'd4, 8'h90);
        drove = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (scl_oe || sda_oe) drove = 1;
        end
        chk(!drove, "R3 no bus activity when off", drove, 0);
        bus_rd(3'd4, r); chk(r[1] == 0, "R3 tip stays clear when off", r[1], 0);
        chk(start_cnt == 0, "R3 no start when off", start_cnt, 0);
        // enable, start + address write (R4, R7)
        bus_wr(3'd2, 8'h80);
        bus_wr(3'd3, 8'h20); bus_wr(3'd4, 8'h90);
        bus_rd(3'd4, r); chk(r[1] == 1, "R6 tip set after accept", r[1], 1);
        wait_tip(st);
        chk(start_cnt == 1 && last_byte == 8'h20, "R4 start then address byte", last_byte, 8'h20);
        chk(st[7] == 0, "R7 slave ack recorded", st[7], 0);
        // plain write, timing reference (R10)
        bus_wr(3'd3, 8'h01);
        t0 = cyc; bus_wr(3'd4, 8'h10); wait_tip(st); t_plain = cyc - t0;
        chk(last_byte == 8'h01, "R7 write byte MSB first", last_byte, 8'h01);
        chk(last_high == 8, "R10 SCL high time", last_high, 8);
        // write with a stretch (R11)
        bus_wr(3'd3, 8'hA5);
        t0 = cyc; bus_wr(3'd4, 8'h10);
        repeat (40) @(negedge clk);
        while (!scl_oe) @(negedge clk);
        stretch = 1;
        repeat (300) @(negedge clk);
        bus_rd(3'd4, r); chk(r[1] == 1, "R11 tip held during stretch", r[1], 1);
        stretch = 0;
        wait_tip(st); t_str = cyc - t0;
        chk(t_str >= t_plain + 250, "R11 stretch delays bit timing", t_str, t_plain + 250);
        chk(last_byte == 8'hA5, "R11 byte intact after stretch", last_byte, 8'hA5);
        // repeated start with read address (R5)
        s0 = stop_cnt;
        bus_wr(3'd3, 8'h21); bus_wr(3'd4, 8'h90); wait_tip(st);
        chk(start_cnt == 2 && stop_cnt == s0, "R5 repeated start without stop", stop_cnt, s0);
        // read with ACK, then with NACK (R8, R4 bit 3)
        bus_wr(3'd4, 8'h20); wait_tip(st);
        bus_rd(3'd3, r); chk(r == 8'h3C, "R8 read byte", r, 8'h3C);
        chk(mack == 0, "R8 master ack level", mack, 0);
        bus_wr(3'd4, 8'h28); wait_tip(st);
        bus_rd(3'd3, r); chk(r == 8'hC3, "R8 second read byte", r, 8'hC3);
        chk(mack == 1, "R4 nack bit sent", mack, 1);
        // stop only (R12)
        p0 = byte_total;
        bus_wr(3'd4, 8'h40); wait_tip(st);
        chk(stop_cnt == s0 + 1 && byte_total == p0, "R12 stop only", stop_cnt, s0 + 1);
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R12 lines released after stop", {scl_oe, sda_oe}, 0);
        // write + stop with NACKing slave (R4, R7)
        bus_wr(3'd3, 8'h20); bus_wr(3'd4, 8'h90); wait_tip(st);
        slave_ack_en = 0;
        bus_wr(3'd3, 8'h77); bus_wr(3'd4, 8'h50); wait_tip(st);
        slave_ack_en = 1;
        chk(st[7] == 1, "R7 NACK in status", st[7], 1);
        chk(stop_cnt == s0 + 2 && bytes_at_stop == byte_total, "R4 stop after byte", bytes_at_stop, byte_total);
        // command while busy is ignored (R6)
        bus_wr(3'd3, 8'h20); bus_wr(3'd4, 8'h90); bus_wr(3'd4, 8'h40);
        wait_tip(st);
        chk(stop_cnt == s0 + 2 && start_cnt == 4, "R6 command while busy ignored", stop_cnt, s0 + 2);
        chk(scl_oe == 1, "R6 bus still owned", scl_oe, 1);
        bus_wr(3'd4, 8'h40); wait_tip(st);
        chk(stop_cnt == s0 + 3, "R12 final stop", stop_cnt, s0 + 3);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule